// File: doc/BRIEF.md
# Dual-Bank Adaptive Echo Canceller

This block is a baud-rate adaptive FIR echo canceller with `NTAPS` taps. Its transceiver adds small deliberate timing steps to either the transmit or the receive clock. As a result, only two relative transmit/receive phases ever fall within the canceller's memory. The block keeps one coefficient bank for each of these two phases: bank G and bank H. Every transmitted symbol is a ±1 value. It enters a delay line together with a one-bit phase tag.

On every baud strobe, each tap chooses its coefficient from G or H according to the tag of the symbol at that delay. The choice follows whatever tag sequence actually arrives: alternating in steady state, constant while a slip is under way. The chosen coefficients are summed into an echo replica with one multiply-accumulate per tap. The replica is subtracted from the received sample. The residual then drives a sign-data LMS update of exactly the coefficients that were used.

A startup mode ties the two banks so that both learn at the full rate. A relabel strobe swaps which bank serves which tag value. The surrounding timing logic pulses it when a slip retires one relative phase and introduces another.

Top module: `dual_bank_ec`

## Requirements
- R1: After reset, `replica`, `residual` and `outValid` are zero, and all coefficients of both banks are zero.
- R2: On a cycle with `baudEn` high, the replica is the sum over taps i = 0..NTAPS-1 of ±c(i). Tap 0 carries the symbol presented in that same cycle, and tap i carries the symbol presented i strobes earlier. `txSym` = 1 means +1 and `txSym` = 0 means -1. Delay positions filled by no symbol since reset hold symbol 0 with tag 0.
- R3: With no relabel since reset, tap i uses bank G when its stored tag is 0 and bank H when its stored tag is 1. This holds for any tag pattern, including long runs of a constant tag.
- R4: `residual` equals `rxSample` minus the replica. Both values appear on the clock edge that follows the `baudEn` cycle. `outValid` is high for exactly that one cycle.
- R5: Outside startup mode, each used coefficient takes the value c + s·(residual >>> `muShift`), where s is the ±1 of the symbol at its tap. The coefficient of the other bank at that tap does not change.
- R6: In startup mode, the same per-tap increment is added to both the G and the H coefficient of every tap, whichever bank that tap read from.
- R7: Each cycle with `relabel` high inverts the tag-to-bank mapping for all later strobes. Two relabels restore the original mapping.
- R8: On cycles with `baudEn` low, the delay line, the coefficients, `replica` and `residual` keep their values, and `outValid` is low. This holds whatever the other inputs carry.
- R9: Coefficient updates saturate at the 16-bit signed limits, +32767 and -32768, instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudEn | input | 1 | One pulse per baud: shift the delay line, cancel, adapt |
| txSym | input | 1 | Transmitted symbol, 1 = +1, 0 = -1 |
| txTag | input | 1 | Phase tag of the transmitted symbol |
| rxSample | input | DW (16) | Received sample, signed |
| startupMode | input | 1 | Ties both banks during adaptation |
| muShift | input | SHIFT_W (5) | LMS step as an arithmetic right shift |
| relabel | input | 1 | Swap the tag-to-bank mapping |
| replica | output | SUM_W (27) | Echo replica, signed |
| residual | output | SUM_W+1 (28) | Received sample minus replica, signed |
| outValid | output | 1 | One-cycle strobe marking new outputs |

## Verification
The canceller is driven by an echo built from two distinct true responses, one for each phase. In tied startup mode, both banks should match each other from the first strobe. Strict alternation of tags makes the G/H interleave across taps visible. A long run of a single tag, as during a slip, would expose any design that alternates banks on a fixed schedule rather than from the stored tags. Idle stretches with noisy inputs, a relabel followed by more alternation, and large samples with zero shift check, in turn, that nothing moves without a strobe, that the mapping really swaps, and that the coefficients clamp instead of wrapping.

// File: rtl/ec_pkg.sv
package ec_pkg;
  typedef struct packed {
    logic       advance;
    logic       tieBanks;
    logic       swapSel;
    logic [4:0] shiftAmt;
  } ec_ctl_t;
endpackage

// File: rtl/ec_ctrl.sv
module ec_ctrl
  import ec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudEn,
  input  logic       startupMode,
  input  logic [4:0] muShift,
  input  logic       relabel,
  output ec_ctl_t    ctl
);
  logic swapReg;

  always_ff @(posedge clk) begin
    if (!rstN) swapReg <= 1'b0;
    else if (relabel) swapReg <= ~swapReg;
  end

  always_comb begin
    ctl.advance  = baudEn;
    ctl.tieBanks = startupMode;
    ctl.swapSel  = swapReg;
    ctl.shiftAmt = muShift;
  end

  a_r7_swap_toggles: assert property (@(posedge clk) disable iff (!rstN)
    relabel |=> (swapReg != $past(swapReg)));
  a_r7_swap_holds: assert property (@(posedge clk) disable iff (!rstN)
    !relabel |=> $stable(swapReg));
endmodule

// File: rtl/ec_datapath.sv
module ec_datapath
  import ec_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int ACC_W = 24,
  localparam int SUM_W = ACC_W + $clog2(NTAPS),
  localparam int ERR_W = SUM_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ec_ctl_t                 ctl,
  input  logic                    txSym,
  input  logic                    txTag,
  input  logic signed [DW-1:0]    rxSample,
  output logic signed [SUM_W-1:0] replica,
  output logic signed [ERR_W-1:0] residual,
  output logic                    outValid
);
  localparam int EXT_W = ERR_W + 1;
  localparam logic signed [EXT_W-1:0] CMAX = {{(EXT_W-CW+1){1'b0}}, {(CW-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] CMIN = {{(EXT_W-CW+1){1'b1}}, {(CW-1){1'b0}}};

  logic symLine [NTAPS-1];
  logic tagLine [NTAPS-1];
  logic curSym  [NTAPS];
  logic curTag  [NTAPS];
  logic selH    [NTAPS];
  logic signed [CW-1:0]    coefG [NTAPS];
  logic signed [CW-1:0]    coefH [NTAPS];
  logic signed [SUM_W-1:0] prod  [NTAPS];
  logic signed [EXT_W-1:0] delta [NTAPS];
  logic signed [SUM_W-1:0] sumNow;
  logic signed [ERR_W-1:0] errNow;
  logic signed [ERR_W-1:0] stepNow;
  logic signed [EXT_W-1:0] stepExt;

  function automatic logic signed [CW-1:0] satAdd(logic signed [CW-1:0] c,
                                                  logic signed [EXT_W-1:0] d);
    logic signed [EXT_W-1:0] s;
    s = {{(EXT_W-CW){c[CW-1]}}, c} + d;
    if (s > CMAX) return CMAX[CW-1:0];
    if (s < CMIN) return CMIN[CW-1:0];
    return s[CW-1:0];
  endfunction

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    if (i == 0) begin : g_head
      assign curSym[i] = txSym;
      assign curTag[i] = txTag;
    end else begin : g_line
      assign curSym[i] = symLine[i-1];
      assign curTag[i] = tagLine[i-1];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          symLine[i-1] <= 1'b0;
          tagLine[i-1] <= 1'b0;
        end else if (ctl.advance) begin
          symLine[i-1] <= curSym[i-1];
          tagLine[i-1] <= curTag[i-1];
        end
      end
    end

    logic signed [CW-1:0] cUsed;
    assign selH[i]  = curTag[i] ^ ctl.swapSel;
    assign cUsed    = selH[i] ? coefH[i] : coefG[i];
    assign prod[i]  = curSym[i] ? SUM_W'(cUsed) : -SUM_W'(cUsed);
    assign delta[i] = curSym[i] ? stepExt : -stepExt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        coefG[i] <= '0;
        coefH[i] <= '0;
      end else if (ctl.advance) begin
        if (ctl.tieBanks || !selH[i]) coefG[i] <= satAdd(coefG[i], delta[i]);
        if (ctl.tieBanks ||  selH[i]) coefH[i] <= satAdd(coefH[i], delta[i]);
      end
    end

    a_r8_coef_hold: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.advance |=> ($stable(coefG[i]) && $stable(coefH[i])));
    a_r5_idle_bank_g: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.advance && !ctl.tieBanks && selH[i]) |=> $stable(coefG[i]));
    a_r5_idle_bank_h: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.advance && !ctl.tieBanks && !selH[i]) |=> $stable(coefH[i]));
  end

  always_comb begin
    sumNow = '0;
    for (int i = 0; i < NTAPS; i++) sumNow = sumNow + prod[i];
  end

  assign errNow  = ERR_W'(rxSample) - ERR_W'(sumNow);
  assign stepNow = errNow >>> ctl.shiftAmt;
  assign stepExt = EXT_W'(stepNow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      replica  <= '0;
      residual <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.advance;
      if (ctl.advance) begin
        replica  <= sumNow;
        residual <= errNow;
      end
    end
  end

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> outValid);
  a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.advance |=> (!outValid && $stable(replica) && $stable(residual)));
  a_r4_residual_sum: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (residual + ERR_W'(replica) == ERR_W'($past(rxSample))));
endmodule

// File: rtl/dual_bank_ec.sv
module dual_bank_ec
  import ec_pkg::*;
#(
  parameter int NTAPS   = 8,
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int ACC_W   = 24,
  parameter int SHIFT_W = 5,
  localparam int SUM_W = ACC_W + $clog2(NTAPS),
  localparam int ERR_W = SUM_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    baudEn,
  input  logic                    txSym,
  input  logic                    txTag,
  input  logic signed [DW-1:0]    rxSample,
  input  logic                    startupMode,
  input  logic [SHIFT_W-1:0]      muShift,
  input  logic                    relabel,
  output logic signed [SUM_W-1:0] replica,
  output logic signed [ERR_W-1:0] residual,
  output logic                    outValid
);
  ec_ctl_t ctl;

  ec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .baudEn(baudEn), .startupMode(startupMode),
    .muShift(5'(muShift)), .relabel(relabel), .ctl(ctl)
  );

  ec_datapath #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txSym(txSym), .txTag(txTag),
    .rxSample(rxSample), .replica(replica), .residual(residual),
    .outValid(outValid)
  );
endmodule

// File: tb/dual_bank_ec_tb_top.sv
module dual_bank_ec_tb_top;
  localparam int NT = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudEn = 1'b0, txSym = 1'b0, txTag = 1'b0, startupMode = 1'b0, relabel = 1'b0;
  logic signed [15:0] rxSample = '0;
  logic [4:0] muShift = 5'd3;
  logic signed [26:0] replica;
  logic signed [27:0] residual;
  logic outValid;

  int checks = 0, fails = 0;
  longint mG[NT], mH[NT], tG[NT], tH[NT];
  int lineS[NT], lineT[NT];
  int mSwap = 0;
  longint expRep = 0, expRes = 0;
  int expVal = 0;

  always #2 clk = ~clk;

  dual_bank_ec dut_i (
    .clk(clk), .rstN(rstN), .baudEn(baudEn), .txSym(txSym), .txTag(txTag),
    .rxSample(rxSample), .startupMode(startupMode), .muShift(muShift),
    .relabel(relabel), .replica(replica), .residual(residual), .outValid(outValid)
  );

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: compare outputs due from the previous cycle, then drive and predict
  task automatic step(string req, bit en, bit s, bit t, longint rx, bit st, int mu, bit rl);
    @(negedge clk);
    chk(req, "replica", replica, expRep);
    chk(req, "residual", residual, expRes);
    chk(req, "outValid", outValid, expVal);
    baudEn = en; txSym = s; txTag = t; rxSample = 16'(rx);
    startupMode = st; muShift = 5'(mu); relabel = rl;
    expVal = en;
    if (en) begin
      longint rep = 0, err, stp;
      for (int i = NT - 1; i > 0; i--) begin lineS[i] = lineS[i-1]; lineT[i] = lineT[i-1]; end
      lineS[0] = s; lineT[0] = t;
      for (int i = 0; i < NT; i++) begin
        longint c = ((lineT[i] ^ mSwap) != 0) ? mH[i] : mG[i];
        rep += (lineS[i] != 0) ? c : -c;
      end
      err = rx - rep;
      stp = err >>> mu;
      for (int i = 0; i < NT; i++) begin
        longint d = (lineS[i] != 0) ? stp : -stp;
        bit useH = (lineT[i] ^ mSwap) != 0;
        if (st || !useH) mG[i] = sat16(mG[i] + d);
        if (st || useH)  mH[i] = sat16(mH[i] + d);
      end
      expRep = rep; expRes = err;
    end
    if (rl) mSwap ^= 1;
  endtask

  function automatic longint echoOf();
    longint e = 0;
    for (int i = 0; i < NT; i++) begin
      longint c = (lineT[i] != 0) ? tH[i] : tG[i];
      e += (lineS[i] != 0) ? c : -c;
    end
    return sat16(e);
  endfunction

  // baud driven by an echo of the true responses; the line is peeked one slot ahead
  task automatic echoBaud(string req, bit t, bit st, int mu);
    bit s = 1'($urandom);
    int keepS[NT], keepT[NT];
    longint rx;
    keepS = lineS; keepT = lineT;
    for (int i = NT - 1; i > 0; i--) begin lineS[i] = lineS[i-1]; lineT[i] = lineT[i-1]; end
    lineS[0] = s; lineT[0] = t;
    rx = echoOf() + longint'($urandom_range(6)) - 3;
    lineS = keepS; lineT = keepT;
    step(req, 1'b1, s, t, rx, st, mu, 1'b0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) begin
      mG[i] = 0; mH[i] = 0; lineS[i] = 0; lineT[i] = 0;
      tG[i] = 4000 >>> i; tH[i] = 3000 - 400 * i;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    step("R1", 0, 0, 0, 0, 0, 3, 0);
    step("R1", 0, 1, 1, 1234, 0, 3, 0);
    // R6: tied banks during startup, R2 sums
    for (int n = 0; n < 60; n++) echoBaud("R6", 1'(n % 2), 1'b1, 3);
    // R3/R5: steady alternation
    for (int n = 0; n < 80; n++) echoBaud("R5", 1'(n % 2), 1'b0, 3);
    // R3: constant tag stretch as in a slip
    for (int n = 0; n < 30; n++) echoBaud("R3", 1'b1, 1'b0, 2);
    // R2: interleaved idle cycles, R4 strobe timing
    for (int n = 0; n < 10; n++) begin
      echoBaud("R2", 1'(n % 2), 1'b0, 4);
      step("R4", 0, 1'($urandom), 1'($urandom), 0, 0, 4, 0);
    end
    // R8: idle with noisy inputs, then a baud exposes the untouched state
    for (int n = 0; n < 6; n++)
      step("R8", 0, 1'($urandom), 1'($urandom), longint'($urandom_range(60000)) - 30000, 1, 0, 0);
    echoBaud("R8", 1'b0, 1'b0, 3);
    // R7: relabel, alternate, relabel back
    step("R7", 0, 0, 0, 0, 0, 3, 1);
    for (int n = 0; n < 30; n++) echoBaud("R7", 1'(n % 2), 1'b0, 3);
    step("R7", 0, 0, 0, 0, 0, 3, 1);
    for (int n = 0; n < 10; n++) echoBaud("R7", 1'(n % 2), 1'b0, 3);
    // R9: saturation both ways with zero shift
    for (int n = 0; n < 8; n++) step("R9", 1, 1, 1'(n % 2), 32767, 0, 0, 0);
    for (int n = 0; n < 8; n++) step("R9", 1, 1, 1'(n % 2), -32768, 1, 0, 0);
    for (int n = 0; n < 4; n++) step("R9", 0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule